// File: doc/BRIEF.md
# Bit-Serial Memory Bus Master

This block sits on the processor side of a memory that talks over one data line using ordinary bus strobes. It takes byte-level requests (read a run of bytes, write part of one 64-byte page, poll for the end of a nonvolatile write) and expands each into the exact chain of single-bit bus cycles the memory understands. A bus cycle is either a read cycle (chip enable and output enable low, one bit sampled from the data-in line) or a write cycle (chip enable and write enable low, one bit driven on the data-out line).

Read and write requests open with a three-cycle reset preamble and a 16-bit address sent most significant bit first. A read then gathers bytes from groups of eight read cycles and closes with a write cycle carrying 1. A write sends the bytes as write cycles and closes with the start trailer (read, write 1, read). Bytes to be written arrive on a valid/ready stream and read bytes leave on another. The strobe low time, the minimum strobe high time and the poll limit are configuration inputs, latched when a command is accepted.

Top module: `bsm_top`

## Requirements
- R1: An accepted read or write command first issues a read cycle, a write cycle carrying 0 and a read cycle, before any other bus cycle.
- R2: After the preamble the 16 address bits are issued as write cycles, most significant bit first, with no read cycle among them.
- R3: A read command issues 8 read cycles per byte, first sampled bit becoming bit 7; each byte is presented on rdData with rdValid, and held unchanged until rdReady; after the last byte exactly one write cycle carrying 1 is issued.
- R4: A write command takes each byte from wrData on a wrValid/wrReady handshake and issues it as 8 write cycles, bit 7 first; after the last byte it issues a read cycle, a write cycle carrying 1 and a read cycle, then returns to idle.
- R5: cmdOp encodes 0 = read, 1 = write, 2 = poll, 3 = invalid. An invalid op, a read of length 0, or a write whose length is 0, above 64, or whose last byte falls beyond the 64-byte page of cmdAddr (cmdAddr[5:0] + cmdLen > 64) is accepted and answered with a one-cycle errFlag pulse and no bus cycle at all.
- R6: A poll command issues read cycles with no preamble until one samples 1, then pulses doneFlag once.
- R7: If cfgPollMax consecutive poll reads (0 counts as 1) all sample 0, timeoutFlag pulses once and the next command, a poll included, starts with the reset preamble; after that preamble later polls again start without one.
- R8: Chip enable stays low for exactly cfgLowCyc clocks per bus cycle and high for at least cfgHighCyc clocks between bus cycles; a setting of 0 acts as 1.
- R9: Output enable and write enable are never low together and are low only while chip enable is low; read cycles use output enable, write cycles use write enable.
- R10: busDout does not change while chip enable is low nor on the clock at which chip enable returns high.
- R11: After reset all three strobes are high, cmdReady is 1, and rdValid, wrReady and the three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Command accepted when high with cmdValid |
| cmdOp | input | 2 | Command code (see R5) |
| cmdAddr | input | 16 | Start byte address |
| cmdLen | input | 8 | Byte count |
| cfgLowCyc | input | 8 | Strobe low time in clocks |
| cfgHighCyc | input | 8 | Minimum strobe high time in clocks |
| cfgPollMax | input | 16 | Poll read limit |
| wrValid | input | 1 | Write byte available |
| wrReady | output | 1 | Write byte taken when high with wrValid |
| wrData | input | 8 | Write byte |
| rdValid | output | 1 | Read byte available |
| rdReady | input | 1 | Read byte taken when high with rdValid |
| rdData | output | 8 | Read byte |
| errFlag | output | 1 | Rejected command pulse |
| doneFlag | output | 1 | Poll success pulse |
| timeoutFlag | output | 1 | Poll limit reached pulse |
| busCeN | output | 1 | Chip enable, active low |
| busOeN | output | 1 | Output enable, active low |
| busWeN | output | 1 | Write enable, active low |
| busDout | output | 1 | Serial data to the memory |
| busDin | input | 1 | Serial data from the memory |

## Verification
The two functions that meet in one cycle are the end of a bit cycle and a stream handshake: the last read cycle of a byte completes while the consumer holds rdReady low, and a write byte is offered exactly as the previous byte's final bit cycle ends. The bench throttles rdReady on a repeating pattern and keeps wrValid up early, so both collisions recur; a model of the expected bit-cycle order is compared against the decoded bus on every clock, and a byte that changes or vanishes while stalled, or a bus cycle that starts before its byte was taken, is reported.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_POLL  = 2'd2,
    OP_BAD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SRC_ZERO,
    SRC_ONE,
    SRC_ADDR,
    SRC_DATA
  } bitsrc_e;

  // control -> datapath strobes
  typedef struct packed {
    logic    loadCmd;
    logic    startBit;
    logic    startRead;
    bitsrc_e bitSrc;
    logic    shiftAddr;
    logic    loadWrByte;
    logic    shiftData;
    logic    clrBitCnt;
    logic    incBit;
    logic    decByte;
    logic    clrPoll;
    logic    incPoll;
  } strobe_t;
endpackage

// File: rtl/bsm_datapath.sv
module bsm_datapath
  import bsm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int CYC_W  = 8,
  parameter int POLL_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic [LEN_W-1:0]     cmdLen,
  input  logic [CYC_W-1:0]     cfgLowCyc,
  input  logic [CYC_W-1:0]     cfgHighCyc,
  input  logic [POLL_W-1:0]    cfgPollMax,
  input  logic [BYTE_BITS-1:0] wrData,
  input  logic                 busDin,
  output logic                 engIdle,
  output logic                 bitDone,
  output logic                 sampleBit,
  output logic                 addrLast,
  output logic                 byteLast,
  output logic                 bytesLeftOne,
  output logic                 bytesLeftZero,
  output logic                 pollLast,
  output logic [BYTE_BITS-1:0] rdData,
  output logic                 busCeN,
  output logic                 busOeN,
  output logic                 busWeN,
  output logic                 busDout
);
  localparam int BC_W = $clog2(ADDR_W);

  typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH} eng_e;

  eng_e                 engState;
  logic [CYC_W-1:0]     phaseCnt;
  logic [CYC_W-1:0]     lowCfg, highCfg, lowLast, highLast;
  logic [POLL_W-1:0]    pollCfg, pollCnt, pollLastVal;
  logic                 curRead;
  logic                 bitVal;
  logic [ADDR_W-1:0]    addrSr;
  logic [BYTE_BITS-1:0] dataSr;
  logic [BC_W-1:0]      bitCnt;
  logic [LEN_W-1:0]     byteLeft;

  assign lowLast     = (lowCfg == '0)  ? '0 : lowCfg - CYC_W'(1);
  assign highLast    = (highCfg == '0) ? '0 : highCfg - CYC_W'(1);
  assign pollLastVal = (pollCfg == '0) ? '0 : pollCfg - POLL_W'(1);

  always_comb begin
    unique case (stb.bitSrc)
      SRC_ZERO: bitVal = 1'b0;
      SRC_ONE:  bitVal = 1'b1;
      SRC_ADDR: bitVal = addrSr[ADDR_W-1];
      default:  bitVal = dataSr[BYTE_BITS-1];
    endcase
  end

  // bit-cycle engine: low phase, then high phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engState  <= E_IDLE;
      phaseCnt  <= '0;
      curRead   <= 1'b0;
      busDout   <= 1'b1;
      sampleBit <= 1'b0;
    end else begin
      unique case (engState)
        E_IDLE: if (stb.startBit) begin
          engState <= E_LOW;
          phaseCnt <= '0;
          curRead  <= stb.startRead;
          busDout  <= bitVal;
        end
        E_LOW: if (phaseCnt == lowLast) begin
          sampleBit <= busDin;
          engState  <= E_HIGH;
          phaseCnt  <= '0;
        end else begin
          phaseCnt <= phaseCnt + CYC_W'(1);
        end
        default: if (phaseCnt == highLast) begin
          engState <= E_IDLE;
        end else begin
          phaseCnt <= phaseCnt + CYC_W'(1);
        end
      endcase
    end
  end

  assign engIdle = (engState == E_IDLE);
  assign bitDone = (engState == E_HIGH) && (phaseCnt == highLast);
  assign busCeN  = (engState != E_LOW);
  assign busOeN  = !((engState == E_LOW) && curRead);
  assign busWeN  = !((engState == E_LOW) && !curRead);

  // command registers and counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCfg   <= '0;
      highCfg  <= '0;
      pollCfg  <= '0;
      addrSr   <= '0;
      dataSr   <= '0;
      bitCnt   <= '0;
      byteLeft <= '0;
      pollCnt  <= '0;
    end else begin
      if (stb.loadCmd) begin
        lowCfg   <= cfgLowCyc;
        highCfg  <= cfgHighCyc;
        pollCfg  <= cfgPollMax;
        addrSr   <= cmdAddr;
        byteLeft <= cmdLen;
      end else if (stb.shiftAddr) begin
        addrSr <= {addrSr[ADDR_W-2:0], 1'b0};
      end
      if (stb.loadWrByte)     dataSr <= wrData;
      else if (stb.shiftData) dataSr <= {dataSr[BYTE_BITS-2:0], sampleBit};
      if (stb.clrBitCnt)      bitCnt <= '0;
      else if (stb.incBit)    bitCnt <= bitCnt + BC_W'(1);
      if (stb.decByte)        byteLeft <= byteLeft - LEN_W'(1);
      if (stb.clrPoll)        pollCnt <= '0;
      else if (stb.incPoll)   pollCnt <= pollCnt + POLL_W'(1);
    end
  end

  assign addrLast      = (bitCnt == BC_W'(ADDR_W - 1));
  assign byteLast      = (bitCnt == BC_W'(BYTE_BITS - 1));
  assign bytesLeftOne  = (byteLeft == LEN_W'(1));
  assign bytesLeftZero = (byteLeft == '0);
  assign pollLast      = (pollCnt == pollLastVal);
  assign rdData        = dataSr;

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!busOeN && !busWeN));
  // R9
  strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busOeN || !busWeN) |-> !busCeN);
  // R10
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!busCeN) |-> $stable(busDout));
endmodule

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
  import bsm_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int PAGE_BYTES = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdValid,
  input  logic [1:0]                  cmdOp,
  input  logic [$clog2(PAGE_BYTES)-1:0] cmdPageOfs,
  input  logic [LEN_W-1:0]            cmdLen,
  input  logic                        wrValid,
  input  logic                        rdReady,
  input  logic                        engIdle,
  input  logic                        bitDone,
  input  logic                        sampleBit,
  input  logic                        addrLast,
  input  logic                        byteLast,
  input  logic                        bytesLeftOne,
  input  logic                        bytesLeftZero,
  input  logic                        pollLast,
  output logic                        cmdReady,
  output logic                        wrReady,
  output logic                        rdValid,
  output logic                        errFlag,
  output logic                        doneFlag,
  output logic                        timeoutFlag,
  output strobe_t                     stb
);
  localparam int PG_W = $clog2(PAGE_BYTES);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE0, S_PRE1, S_PRE2, S_ADDR, S_WLOAD, S_WBIT,
    S_RBIT, S_ROUT, S_RTERM, S_TR0, S_TR1, S_TR2, S_POLL
  } state_e;

  state_e       state, nextState;
  op_e          curOp;
  logic         needPre, setNeedPre, clrNeedPre;
  logic         errNext, doneNext, toNext;
  logic [LEN_W:0] pageEnd;
  logic         writeOk;

  assign pageEnd = (LEN_W+1)'(cmdPageOfs) + (LEN_W+1)'(cmdLen);
  assign writeOk = (cmdLen != '0) && ((LEN_W+1)'(cmdLen) <= (LEN_W+1)'(PAGE_BYTES))
                   && (pageEnd <= (LEN_W+1)'(PAGE_BYTES));

  always_comb begin
    stb        = '0;
    nextState  = state;
    cmdReady   = 1'b0;
    wrReady    = 1'b0;
    rdValid    = 1'b0;
    errNext    = 1'b0;
    doneNext   = 1'b0;
    toNext     = 1'b0;
    setNeedPre = 1'b0;
    clrNeedPre = 1'b0;
    unique case (state)
      S_IDLE: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          unique case (op_e'(cmdOp))
            OP_READ:
              if (cmdLen == '0) errNext = 1'b1;
              else begin stb.loadCmd = 1'b1; nextState = S_PRE0; end
            OP_WRITE:
              if (!writeOk) errNext = 1'b1;
              else begin stb.loadCmd = 1'b1; nextState = S_PRE0; end
            OP_POLL: begin
              stb.loadCmd = 1'b1;
              stb.clrPoll = 1'b1;
              nextState   = needPre ? S_PRE0 : S_POLL;
            end
            default: errNext = 1'b1;
          endcase
        end
      end
      S_PRE0: begin
        stb.startRead = 1'b1; stb.bitSrc = SRC_ONE;
        if (bitDone) nextState = S_PRE1;
      end
      S_PRE1: begin
        stb.bitSrc = SRC_ZERO;
        if (bitDone) nextState = S_PRE2;
      end
      S_PRE2: begin
        stb.startRead = 1'b1; stb.bitSrc = SRC_ONE;
        if (bitDone) begin
          clrNeedPre = 1'b1;
          stb.clrBitCnt = 1'b1;
          nextState = (curOp == OP_POLL) ? S_POLL : S_ADDR;
        end
      end
      S_ADDR: begin
        stb.bitSrc = SRC_ADDR;
        if (bitDone) begin
          stb.shiftAddr = 1'b1;
          stb.incBit    = 1'b1;
          if (addrLast) begin
            stb.clrBitCnt = 1'b1;
            nextState = (curOp == OP_READ) ? S_RBIT : S_WLOAD;
          end
        end
      end
      S_WLOAD: begin
        wrReady = 1'b1;
        if (wrValid) begin
          stb.loadWrByte = 1'b1;
          nextState = S_WBIT;
        end
      end
      S_WBIT: begin
        stb.bitSrc = SRC_DATA;
        if (bitDone) begin
          stb.shiftData = 1'b1;
          stb.incBit    = 1'b1;
          if (byteLast) begin
            stb.clrBitCnt = 1'b1;
            stb.decByte   = 1'b1;
            nextState = bytesLeftOne ? S_TR0 : S_WLOAD;
          end
        end
      end
      S_RBIT: begin
        stb.startRead = 1'b1; stb.bitSrc = SRC_ONE;
        if (bitDone) begin
          stb.shiftData = 1'b1;
          stb.incBit    = 1'b1;
          if (byteLast) begin
            stb.clrBitCnt = 1'b1;
            stb.decByte   = 1'b1;
            nextState = S_ROUT;
          end
        end
      end
      S_ROUT: begin
        rdValid = 1'b1;
        if (rdReady) nextState = bytesLeftZero ? S_RTERM : S_RBIT;
      end
      S_RTERM: begin
        stb.bitSrc = SRC_ONE;
        if (bitDone) nextState = S_IDLE;
      end
      S_TR0: begin
        stb.startRead = 1'b1; stb.bitSrc = SRC_ONE;
        if (bitDone) nextState = S_TR1;
      end
      S_TR1: begin
        stb.bitSrc = SRC_ONE;
        if (bitDone) nextState = S_TR2;
      end
      S_TR2: begin
        stb.startRead = 1'b1; stb.bitSrc = SRC_ONE;
        if (bitDone) nextState = S_IDLE;
      end
      default: begin
        stb.startRead = 1'b1; stb.bitSrc = SRC_ONE;
        if (bitDone) begin
          if (sampleBit) begin
            doneNext = 1'b1; nextState = S_IDLE;
          end else if (pollLast) begin
            toNext = 1'b1; setNeedPre = 1'b1; nextState = S_IDLE;
          end else begin
            stb.incPoll = 1'b1;
          end
        end
      end
    endcase
    stb.startBit = engIdle && !(state inside {S_IDLE, S_WLOAD, S_ROUT});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      curOp       <= OP_READ;
      needPre     <= 1'b0;
      errFlag     <= 1'b0;
      doneFlag    <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      state       <= nextState;
      errFlag     <= errNext;
      doneFlag    <= doneNext;
      timeoutFlag <= toNext;
      if (stb.loadCmd) curOp <= op_e'(cmdOp);
      if (setNeedPre)      needPre <= 1'b1;
      else if (clrNeedPre) needPre <= 1'b0;
    end
  end

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> rdValid);
  // R5
  err_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> $past(cmdValid && cmdReady));
  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errFlag, doneFlag, timeoutFlag}));
endmodule

// File: rtl/bsm_top.sv
module bsm_top
  import bsm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 8,
  parameter int CYC_W      = 8,
  parameter int POLL_W     = 16,
  parameter int PAGE_BYTES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  output logic                 cmdReady,
  input  logic [1:0]           cmdOp,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic [LEN_W-1:0]     cmdLen,
  input  logic [CYC_W-1:0]     cfgLowCyc,
  input  logic [CYC_W-1:0]     cfgHighCyc,
  input  logic [POLL_W-1:0]    cfgPollMax,
  input  logic                 wrValid,
  output logic                 wrReady,
  input  logic [BYTE_BITS-1:0] wrData,
  output logic                 rdValid,
  input  logic                 rdReady,
  output logic [BYTE_BITS-1:0] rdData,
  output logic                 errFlag,
  output logic                 doneFlag,
  output logic                 timeoutFlag,
  output logic                 busCeN,
  output logic                 busOeN,
  output logic                 busWeN,
  output logic                 busDout,
  input  logic                 busDin
);
  localparam int PG_W = $clog2(PAGE_BYTES);

  strobe_t stb;
  logic engIdle, bitDone, sampleBit, addrLast, byteLast;
  logic bytesLeftOne, bytesLeftZero, pollLast;

  bsm_ctrl #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) i_ctrl (
    .clk, .rstN, .cmdValid, .cmdOp,
    .cmdPageOfs(cmdAddr[PG_W-1:0]), .cmdLen,
    .wrValid, .rdReady, .engIdle, .bitDone, .sampleBit,
    .addrLast, .byteLast, .bytesLeftOne, .bytesLeftZero, .pollLast,
    .cmdReady, .wrReady, .rdValid, .errFlag, .doneFlag, .timeoutFlag, .stb
  );

  bsm_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CYC_W(CYC_W), .POLL_W(POLL_W)) i_dp (
    .clk, .rstN, .stb, .cmdAddr, .cmdLen, .cfgLowCyc, .cfgHighCyc, .cfgPollMax,
    .wrData, .busDin, .engIdle, .bitDone, .sampleBit, .addrLast, .byteLast,
    .bytesLeftOne, .bytesLeftZero, .pollLast, .rdData,
    .busCeN, .busOeN, .busWeN, .busDout
  );

  // R1
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> busCeN);
endmodule

// File: tb/test_bsm_top.sv
module test_bsm_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, cmdReady;
  logic [1:0] cmdOp = 2'd0;
  logic [15:0] cmdAddr = '0;
  logic [7:0] cmdLen = '0;
  logic [7:0] cfgLowCyc = 8'd3, cfgHighCyc = 8'd2;
  logic [15:0] cfgPollMax = 16'd5;
  logic wrValid = 1'b0, wrReady;
  logic [7:0] wrData = '0;
  logic rdValid, rdReady = 1'b1;
  logic [7:0] rdData;
  logic errFlag, doneFlag, timeoutFlag;
  logic busCeN, busOeN, busWeN, busDout;
  logic busDin = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsm_top i_bsm_top (
    .clk, .rstN, .cmdValid, .cmdReady, .cmdOp, .cmdAddr, .cmdLen,
    .cfgLowCyc, .cfgHighCyc, .cfgPollMax, .wrValid, .wrReady, .wrData,
    .rdValid, .rdReady, .rdData, .errFlag, .doneFlag, .timeoutFlag,
    .busCeN, .busOeN, .busWeN, .busDout, .busDin
  );

  int checks = 0, failures = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference model: expected bit cycles in order
  int    qKind[$];   // 0 read, 1 write
  int    qBit[$];
  bit    qDin[$];
  string qTag[$];
  int    rdExp[$];
  int    wrQ[$];
  int    expLow = 3, expHigh = 2;
  int    cycleCount = 0, errSeen = 0, doneSeen = 0, toSeen = 0;
  bit    stallEn = 1'b0;

  task automatic expCyc(int kind, int b, bit din, string tag);
    qKind.push_back(kind); qBit.push_back(b); qDin.push_back(din); qTag.push_back(tag);
  endtask
  task automatic expPre();
    expCyc(0, 0, 1'b1, "R1"); expCyc(1, 0, 1'b1, "R1"); expCyc(0, 0, 1'b1, "R1");
  endtask
  task automatic expAddr(logic [15:0] a);
    for (int i = 15; i >= 0; i--) expCyc(1, int'(a[i]), 1'b1, "R2");
  endtask
  task automatic expRdByte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) expCyc(0, 0, b[i], "R3");
    rdExp.push_back(int'(b));
  endtask
  task automatic expWrByte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) expCyc(1, int'(b[i]), 1'b1, "R4");
    wrQ.push_back(int'(b));
  endtask
  task automatic expTrailer();
    expCyc(0, 0, 1'b1, "R4"); expCyc(1, 1, 1'b1, "R4"); expCyc(0, 0, 1'b1, "R4");
  endtask

  // per-clock monitor and stream agents
  int  lowCnt = 0, highCnt = 100, curKind = 0, curBit = 0;
  bit  prevCe = 1'b1, prevStall = 1'b0, wrPend = 1'b0;
  logic [7:0] prevRd = '0;
  int  stallCtr = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!busOeN && !busWeN) check(0, "R9", "OE and WE low together", 1, 0);
      if ((!busOeN || !busWeN) && busCeN) check(0, "R9", "strobe without CE", 1, 0);
      if (!busCeN) begin
        if (prevCe) begin
          check(highCnt >= expHigh, "R8", "CE high width", highCnt, expHigh);
          lowCnt = 1; curKind = !busOeN ? 0 : 1; curBit = int'(busDout);
          cycleCount++;
        end else begin
          lowCnt++;
          check(int'(busDout) == curBit, "R10", "dout moved in low phase", int'(busDout), curBit);
        end
      end else begin
        if (!prevCe) begin
          check(lowCnt == expLow, "R8", "CE low width", lowCnt, expLow);
          check(int'(busDout) == curBit, "R10", "dout moved at CE rise", int'(busDout), curBit);
          if (qKind.size() == 0) check(0, "R1", "unexpected bus cycle", curKind, -1);
          else begin
            check(curKind == qKind[0], qTag[0], "cycle kind", curKind, qKind[0]);
            if (qKind[0] == 1) check(curBit == qBit[0], qTag[0], "write bit", curBit, qBit[0]);
            void'(qKind.pop_front()); void'(qBit.pop_front());
            void'(qDin.pop_front()); void'(qTag.pop_front());
          end
          highCnt = 1;
        end else highCnt++;
      end
      prevCe = busCeN;
      busDin = (qKind.size() > 0 && qKind[0] == 0) ? qDin[0] : 1'b1;

      if (errFlag) errSeen++;
      if (doneFlag) doneSeen++;
      if (timeoutFlag) toSeen++;

      // read byte consumer
      stallCtr++;
      rdReady = stallEn ? (stallCtr % 3 == 2) : 1'b1;
      if (rdValid) begin
        if (prevStall) check(rdData == prevRd, "R3", "byte changed while stalled", int'(rdData), int'(prevRd));
        if (rdReady) begin
          if (rdExp.size() == 0) check(0, "R3", "unexpected read byte", int'(rdData), -1);
          else begin
            check(int'(rdData) == rdExp[0], "R3", "read byte", int'(rdData), rdExp[0]);
            void'(rdExp.pop_front());
          end
        end
        prevStall = !rdReady; prevRd = rdData;
      end else begin
        if (prevStall) check(0, "R3", "rdValid dropped while stalled", 0, 1);
        prevStall = 1'b0;
      end

      // write byte producer
      if (wrPend) void'(wrQ.pop_front());
      wrValid = (wrQ.size() > 0);
      wrData  = (wrQ.size() > 0) ? 8'(wrQ[0]) : 8'h00;
      wrPend  = wrValid && wrReady;
    end
  end

  task automatic sendCmd(logic [1:0] op, logic [15:0] a, logic [7:0] len);
    @(negedge clk);
    cmdOp = op; cmdAddr = a; cmdLen = len; cmdValid = 1'b1;
    expLow  = (cfgLowCyc == 0) ? 1 : int'(cfgLowCyc);
    expHigh = (cfgHighCyc == 0) ? 1 : int'(cfgHighCyc);
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (qKind.size() != 0 || rdExp.size() != 0 || !cmdReady) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic rejectCase(logic [1:0] op, logic [15:0] a, logic [7:0] len, string what);
    int e0 = errSeen, c0 = cycleCount;
    sendCmd(op, a, len);
    repeat (6) @(negedge clk);
    check(errSeen == e0 + 1, "R5", what, errSeen - e0, 1);
    check(cycleCount == c0, "R5", {what, " bus idle"}, cycleCount - c0, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int d0, t0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check({busCeN, busOeN, busWeN} == 3'b111, "R11", "strobes after reset", int'({busCeN, busOeN, busWeN}), 7);
    check(cmdReady == 1'b1, "R11", "cmdReady after reset", int'(cmdReady), 1);
    check({rdValid, wrReady, errFlag, doneFlag, timeoutFlag} == 5'b0, "R11", "outputs after reset",
          int'({rdValid, wrReady, errFlag, doneFlag, timeoutFlag}), 0);

    // read two bytes (R1 R2 R3)
    expPre(); expAddr(16'h1234); expRdByte(8'hA5); expRdByte(8'h3C); expCyc(1, 1, 1'b1, "R3");
    sendCmd(2'd0, 16'h1234, 8'd2);
    waitIdle();

    // write three bytes (R4)
    expPre(); expAddr(16'h0040); expWrByte(8'h81); expWrByte(8'h5A); expWrByte(8'hFF); expTrailer();
    sendCmd(2'd1, 16'h0040, 8'd3);
    waitIdle();
    check(wrQ.size() == 0, "R4", "all write bytes taken", wrQ.size(), 0);

    // write ending exactly on page end is accepted (R5 boundary)
    expPre(); expAddr(16'h013C); expWrByte(8'h01); expWrByte(8'h80); expWrByte(8'h7E); expWrByte(8'hC3); expTrailer();
    sendCmd(2'd1, 16'h013C, 8'd4);
    waitIdle();

    // rejections (R5)
    rejectCase(2'd1, 16'h003D, 8'd4, "page crossing write");
    rejectCase(2'd1, 16'h0000, 8'd65, "write of 65");
    rejectCase(2'd1, 16'h0000, 8'd0, "write of 0");
    rejectCase(2'd0, 16'h0010, 8'd0, "read of 0");
    rejectCase(2'd3, 16'h0000, 8'd1, "invalid op");

    // poll success without preamble (R6)
    d0 = doneSeen;
    expCyc(0, 0, 1'b0, "R6"); expCyc(0, 0, 1'b0, "R6"); expCyc(0, 0, 1'b1, "R6");
    sendCmd(2'd2, 16'h0000, 8'd0);
    waitIdle();
    check(doneSeen == d0 + 1, "R6", "doneFlag pulses", doneSeen - d0, 1);

    // poll timeout (R7)
    t0 = toSeen; d0 = doneSeen;
    for (int i = 0; i < 5; i++) expCyc(0, 0, 1'b0, "R7");
    sendCmd(2'd2, 16'h0000, 8'd0);
    waitIdle();
    check(toSeen == t0 + 1, "R7", "timeoutFlag pulses", toSeen - t0, 1);
    check(doneSeen == d0, "R7", "no done on timeout", doneSeen - d0, 0);

    // next poll carries preamble (R7)
    expPre(); expCyc(0, 0, 1'b1, "R7");
    sendCmd(2'd2, 16'h0000, 8'd0);
    waitIdle();
    check(doneSeen == d0 + 1, "R7", "poll after timeout done", doneSeen - d0, 1);

    // and the one after does not (R7)
    expCyc(0, 0, 1'b1, "R7");
    sendCmd(2'd2, 16'h0000, 8'd0);
    waitIdle();
    check(doneSeen == d0 + 2, "R7", "plain poll again", doneSeen - d0, 2);

    // short strobes, zero low setting, throttled consumer (R8 R3)
    cfgLowCyc = 8'd0; cfgHighCyc = 8'd1; stallEn = 1'b1;
    expPre(); expAddr(16'hFFFF); expRdByte(8'h00); expRdByte(8'hFF); expRdByte(8'h96); expCyc(1, 1, 1'b1, "R3");
    sendCmd(2'd0, 16'hFFFF, 8'd3);
    waitIdle();
    stallEn = 1'b0;

    // long strobes on a one-byte write (R8 R4)
    cfgLowCyc = 8'd5; cfgHighCyc = 8'd4;
    expPre(); expAddr(16'h8000); expWrByte(8'h6D); expTrailer();
    sendCmd(2'd1, 16'h8000, 8'd1);
    waitIdle();

    check(qKind.size() == 0, "R1", "expected cycles all seen", qKind.size(), 0);
    check(rdExp.size() == 0, "R3", "expected bytes all seen", rdExp.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule